// File: doc/BRIEF.md
# Gated 16-bit Timer/Counter

This block is a 16-bit incrementing counter. Software reads and writes it as two 8-bit halves. The count source is either the internal instruction clock, which is the core clock divided by four, or an external clock input. The external clock can pass through a two-flop synchronizer or be used without one.

A prescaler sits between the selected source and the counter and divides by 1, 2, 4 or 8. Counting can also be held back by a gate, taken either from a dedicated pin or from a comparator output, with selectable polarity.

When the counter wraps from all ones to zero, a sticky overflow flag is set. The flag stays set until a clear strobe arrives. The interrupt output is the flag qualified by an enable bit. A write to either half takes effect at once and restarts the prescaler.

Top module: `gated_timer16`

## Requirements
- R1: After reset the counter reads 0x0000, the overflow flag is 0 and the interrupt output is 0.
- R2: A write strobe on the low (high) half loads that byte from the write data on the next clock edge and leaves the other byte unchanged. The readback ports show the new value from the following cycle.
- R3: The control register bit layout is: bit0 run, bit1 external select, bit2 no-sync, bits5:3 prescale select, bit6 gate enable, bit7 gate from comparator, bit8 gate active-high, bit9 interrupt enable. With external select at 0, the counter advances once per prescale ratio of instruction ticks. One instruction tick occurs every 4 core clocks.
- R4: The prescale ratio is 2 to the power of the low two select bits (1, 2, 4 or 8). Select bit 2 is ignored.
- R5: With external select at 1 and no-sync at 1, a rising external edge seen at a core clock edge counts at that same edge. With no-sync at 0 it counts two core clocks later.
- R6: With gate enable at 1, counting happens only while the gate is active. The gate comes from the gate pin (bit7=0) or the comparator input (bit7=1). It is active-low when bit8=0 and active-high when bit8=1. With gate enable at 0, both gate inputs have no effect.
- R7: A wrap from 0xFFFF to 0x0000 sets the overflow flag. The flag stays set until the clear strobe, and a wrap in the same cycle as a clear wins. The interrupt output equals the flag ANDed with the interrupt enable bit.
- R8: A write to either counter byte resets the prescaler, so a full prescale ratio of source ticks is needed before the next increment.
- R9: With run at 0, the counter holds its value regardless of source ticks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rstN | input | 1 | Active-low synchronous reset |
| ctrlWe | input | 1 | Control register write strobe |
| ctrlWdata | input | 10 | Control register write data |
| wrLo | input | 1 | Low byte write strobe |
| wrHi | input | 1 | High byte write strobe |
| wrData | input | 8 | Byte write data |
| rdLo | output | 8 | Counter low byte |
| rdHi | output | 8 | Counter high byte |
| extClk | input | 1 | External count clock |
| gatePin | input | 1 | Gate pin input |
| cmpOut | input | 1 | Comparator output used as gate |
| flagClr | input | 1 | Overflow flag clear strobe |
| ovfFlag | output | 1 | Sticky overflow flag |
| irq | output | 1 | Qualified interrupt |

## Verification
Faults in the prescaler state or the instruction-clock phase appear on the readback ports as a wrong count within one prescale period. For that reason each ratio is checked over a window that is an exact multiple of four times the ratio. A missing or extra synchronizer stage shows up as a one-cycle shift in when a single external pulse is counted, and single-pulse checks sample at that exact cycle. A faulty flag path shows up on ovfFlag and irq in the cycle right after the wrap or the clear.

// File: rtl/gtmr_pkg.sv
package gtmr_pkg;
  localparam int BYTE_W = 8;
  localparam int CNT_W  = 2 * BYTE_W;
  localparam int CTRL_W = 10;

  // Packed MSB first: bit9 irqEn ... bit0 run
  typedef struct packed {
    logic       irqEn;
    logic       gateHigh;
    logic       gateCmp;
    logic       gateEn;
    logic [2:0] preSel;
    logic       noSync;
    logic       extSel;
    logic       run;
  } ctrlReg_t;

  typedef struct packed {
    logic incr;
    logic loadLo;
    logic loadHi;
  } dpStrobe_t;
endpackage

// File: rtl/gtmr_ctrl.sv
module gtmr_ctrl
  import gtmr_pkg::*;
#(
  parameter int INSTR_DIV   = 4,
  parameter int PRE_USE     = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              ctrlWe,
  input  logic [CTRL_W-1:0] ctrlWdata,
  input  logic              extClk,
  input  logic              gatePin,
  input  logic              cmpOut,
  input  logic              wrLo,
  input  logic              wrHi,
  output ctrlReg_t          ctrlQ,
  output dpStrobe_t         strobe
);
  localparam int PH_W      = $clog2(INSTR_DIV);
  localparam int PRE_CNT_W = (1 << PRE_USE) - 1;

  logic [PH_W-1:0]      phase;
  logic                 instrTick;
  logic [SYNC_STAGES:0] syncSh;
  logic                 rawQ;
  logic                 syncPulse;
  logic                 asyncPulse;
  logic                 srcTick;
  logic                 gateRaw;
  logic                 gateActive;
  logic                 countOk;
  logic                 anyWr;
  logic [PRE_CNT_W-1:0] preCnt;
  logic [PRE_CNT_W-1:0] preLimit;
  logic                 preLast;

  always_ff @(posedge clk) begin
    if (!rstN) ctrlQ <= '0;
    else if (ctrlWe) ctrlQ <= ctrlReg_t'(ctrlWdata);
  end

  // Instruction clock phase
  assign instrTick = (phase == PH_W'(INSTR_DIV - 1));
  always_ff @(posedge clk) begin
    if (!rstN) phase <= '0;
    else phase <= instrTick ? '0 : phase + PH_W'(1);
  end

  // External clock: synchronized chain plus edge flop, and raw edge path
  always_ff @(posedge clk) begin
    if (!rstN) begin
      syncSh <= '0;
      rawQ   <= 1'b0;
    end else begin
      syncSh <= {syncSh[SYNC_STAGES-1:0], extClk};
      rawQ   <= extClk;
    end
  end
  assign syncPulse  = syncSh[SYNC_STAGES-1] & ~syncSh[SYNC_STAGES];
  assign asyncPulse = extClk & ~rawQ;

  assign srcTick = ctrlQ.extSel ? (ctrlQ.noSync ? asyncPulse : syncPulse)
                                : instrTick;

  // Gate
  assign gateRaw    = ctrlQ.gateCmp ? cmpOut : gatePin;
  assign gateActive = ctrlQ.gateHigh ? gateRaw : ~gateRaw;
  assign countOk    = ctrlQ.run & (~ctrlQ.gateEn | gateActive);

  // Prescaler
  assign anyWr    = wrLo | wrHi;
  assign preLimit = (PRE_CNT_W'(1) << ctrlQ.preSel[PRE_USE-1:0]) - PRE_CNT_W'(1);
  assign preLast  = (preCnt >= preLimit);

  always_ff @(posedge clk) begin
    if (!rstN || anyWr) preCnt <= '0;
    else if (countOk && srcTick) preCnt <= preLast ? '0 : preCnt + PRE_CNT_W'(1);
  end

  assign strobe.incr   = countOk & srcTick & preLast & ~anyWr;
  assign strobe.loadLo = wrLo;
  assign strobe.loadHi = wrHi;
endmodule

// File: rtl/gtmr_dp.sv
module gtmr_dp
  import gtmr_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobe_t         strobe,
  input  logic [BYTE_W-1:0] wrData,
  input  logic              flagClr,
  input  logic              irqEn,
  output logic [CNT_W-1:0]  cntQ,
  output logic              ovfFlag,
  output logic              irq
);
  logic wrap;

  assign wrap = strobe.incr & (cntQ == '1);

  always_ff @(posedge clk) begin
    if (!rstN) cntQ <= '0;
    else if (strobe.loadLo || strobe.loadHi) begin
      if (strobe.loadHi) cntQ[CNT_W-1:BYTE_W] <= wrData;
      if (strobe.loadLo) cntQ[BYTE_W-1:0]     <= wrData;
    end else if (strobe.incr) cntQ <= cntQ + CNT_W'(1);
  end

  always_ff @(posedge clk) begin
    if (!rstN) ovfFlag <= 1'b0;
    else if (wrap) ovfFlag <= 1'b1;
    else if (flagClr) ovfFlag <= 1'b0;
  end

  assign irq = ovfFlag & irqEn;
endmodule

// File: rtl/gated_timer16.sv
module gated_timer16
  import gtmr_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              ctrlWe,
  input  logic [CTRL_W-1:0] ctrlWdata,
  input  logic              wrLo,
  input  logic              wrHi,
  input  logic [BYTE_W-1:0] wrData,
  output logic [BYTE_W-1:0] rdLo,
  output logic [BYTE_W-1:0] rdHi,
  input  logic              extClk,
  input  logic              gatePin,
  input  logic              cmpOut,
  input  logic              flagClr,
  output logic              ovfFlag,
  output logic              irq
);
  ctrlReg_t         ctrlQ;
  dpStrobe_t        strobe;
  logic [CNT_W-1:0] cntQ;

  gtmr_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .ctrlWe(ctrlWe), .ctrlWdata(ctrlWdata),
    .extClk(extClk), .gatePin(gatePin), .cmpOut(cmpOut),
    .wrLo(wrLo), .wrHi(wrHi), .ctrlQ(ctrlQ), .strobe(strobe)
  );

  gtmr_dp u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .wrData(wrData),
    .flagClr(flagClr), .irqEn(ctrlQ.irqEn), .cntQ(cntQ),
    .ovfFlag(ovfFlag), .irq(irq)
  );

  assign rdLo = cntQ[BYTE_W-1:0];
  assign rdHi = cntQ[CNT_W-1:BYTE_W];
endmodule

// File: rtl/gtmr_chk.sv
module gtmr_chk (
  input logic       clk,
  input logic       rstN,
  input logic       wrLo,
  input logic       wrHi,
  input logic [7:0] wrData,
  input logic       flagClr,
  input logic       run,
  input logic       irqEn,
  input logic [7:0] rdLo,
  input logic [7:0] rdHi,
  input logic       ovfFlag,
  input logic       irq
);
  a_r2_lo_load: assert property (@(posedge clk) disable iff (!rstN)
    wrLo |=> rdLo == $past(wrData));

  a_r2_hi_load: assert property (@(posedge clk) disable iff (!rstN)
    wrHi |=> rdHi == $past(wrData));

  a_r3_step: assert property (@(posedge clk) disable iff (!rstN)
    (!wrLo && !wrHi) |=> ({rdHi, rdLo} == $past({rdHi, rdLo}) ||
                          {rdHi, rdLo} == $past({rdHi, rdLo}) + 16'd1));

  a_r9_hold: assert property (@(posedge clk) disable iff (!rstN)
    (!run && !wrLo && !wrHi) |=> $stable({rdHi, rdLo}));

  a_r7_set: assert property (@(posedge clk) disable iff (!rstN)
    ({rdHi, rdLo} == 16'hFFFF && !wrLo && !wrHi) |=>
      ({rdHi, rdLo} == 16'hFFFF || ovfFlag));

  a_r7_sticky: assert property (@(posedge clk) disable iff (!rstN)
    (ovfFlag && !flagClr) |=> ovfFlag);

  a_r7_clear: assert property (@(posedge clk) disable iff (!rstN)
    (flagClr && {rdHi, rdLo} != 16'hFFFF) |=> !ovfFlag);

  a_r7_irq_gate: assert property (@(posedge clk) disable iff (!rstN)
    (!irqEn || !ovfFlag) |-> !irq);
endmodule

bind gated_timer16 gtmr_chk u_chk (
  .clk(clk), .rstN(rstN), .wrLo(wrLo), .wrHi(wrHi), .wrData(wrData),
  .flagClr(flagClr), .run(ctrlQ.run), .irqEn(ctrlQ.irqEn),
  .rdLo(rdLo), .rdHi(rdHi), .ovfFlag(ovfFlag), .irq(irq)
);

// File: tb/gated_timer16_tb.sv
`timescale 1ns/1ps
module gated_timer16_tb;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       ctrlWe = 1'b0;
  logic [9:0] ctrlWdata = '0;
  logic       wrLo = 1'b0, wrHi = 1'b0;
  logic [7:0] wrData = '0;
  logic [7:0] rdLo, rdHi;
  logic       extClk = 1'b0, gatePin = 1'b0, cmpOut = 1'b0, flagClr = 1'b0;
  logic       ovfFlag, irq;
  int         errors = 0;
  int         checks = 0;

  always #2.5 clk = ~clk;

  gated_timer16 u_dut (
    .clk(clk), .rstN(rstN), .ctrlWe(ctrlWe), .ctrlWdata(ctrlWdata),
    .wrLo(wrLo), .wrHi(wrHi), .wrData(wrData), .rdLo(rdLo), .rdHi(rdHi),
    .extClk(extClk), .gatePin(gatePin), .cmpOut(cmpOut),
    .flagClr(flagClr), .ovfFlag(ovfFlag), .irq(irq)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [9:0] mk(input logic run, input logic ext, input logic noSync,
                                    input logic [2:0] pre, input logic gEn, input logic gCmp,
                                    input logic gHigh, input logic ie);
    return {ie, gHigh, gCmp, gEn, pre, noSync, ext, run};
  endfunction

  task automatic setCtrl(input logic [9:0] v);
    @(negedge clk); ctrlWe = 1'b1; ctrlWdata = v;
    @(negedge clk); ctrlWe = 1'b0;
  endtask

  task automatic writeCnt(input logic [15:0] v);
    @(negedge clk); wrHi = 1'b1; wrData = v[15:8];
    @(negedge clk); wrHi = 1'b0; wrLo = 1'b1; wrData = v[7:0];
    @(negedge clk); wrLo = 1'b0;
  endtask

  task automatic runCycles(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic pulses(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); extClk = 1'b1;
      @(negedge clk); extClk = 1'b0;
    end
    runCycles(3);
  endtask

  function automatic logic [15:0] cnt();
    return {rdHi, rdLo};
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1 count", cnt(), 16'h0000);
    check("R1 flag", ovfFlag, 0);
    check("R1 irq", irq, 0);

    // R2 byte writes with counting off
    setCtrl(mk(0, 0, 0, 0, 0, 0, 0, 0));
    @(negedge clk); wrHi = 1'b1; wrData = 8'hAB;
    @(negedge clk); wrHi = 1'b0;
    check("R2 hi byte", cnt(), 16'hAB00);
    wrLo = 1'b1; wrData = 8'h5C;
    @(negedge clk); wrLo = 1'b0;
    check("R2 lo byte keeps hi", cnt(), 16'hAB5C);
    wrHi = 1'b1; wrData = 8'h12;
    @(negedge clk); wrHi = 1'b0;
    check("R2 hi byte keeps lo", cnt(), 16'h125C);

    // R9 hold with run off, internal and external sources
    runCycles(40);
    check("R9 hold internal", cnt(), 16'h125C);
    setCtrl(mk(0, 1, 1, 0, 0, 0, 0, 0));
    pulses(5);
    check("R9 hold external", cnt(), 16'h125C);

    // R3 / R4 internal clock over every select value (bit 2 ignored)
    for (int s = 0; s < 8; s++) begin
      int r;
      r = 1 << (s & 3);
      setCtrl(mk(1, 0, 0, 3'(s), 0, 0, 0, 0));
      writeCnt(16'h1234);
      runCycles(4 * r * 3);
      check($sformatf("R3 R4 internal sel=%0d", s), cnt(), 16'h1237);
    end

    // R4 external unsynchronized, each ratio, boundary one pulse short
    for (int s = 0; s < 4; s++) begin
      int r;
      r = 1 << s;
      setCtrl(mk(1, 1, 1, 3'(s), 0, 0, 0, 0));
      writeCnt(16'h0200);
      pulses(3 * r - 1);
      check($sformatf("R4 ext ratio=%0d short", r), cnt(), 16'h0202);
      pulses(1);
      check($sformatf("R4 ext ratio=%0d full", r), cnt(), 16'h0203);
    end

    // R5 latency: unsynchronized vs synchronized
    setCtrl(mk(1, 1, 1, 0, 0, 0, 0, 0));
    writeCnt(16'h0100);
    @(negedge clk); extClk = 1'b1;
    @(negedge clk); extClk = 1'b0;
    check("R5 async same edge", cnt(), 16'h0101);
    setCtrl(mk(1, 1, 0, 0, 0, 0, 0, 0));
    writeCnt(16'h0100);
    @(negedge clk); extClk = 1'b1;
    @(negedge clk); extClk = 1'b0;
    check("R5 sync after 1 edge", cnt(), 16'h0100);
    @(negedge clk);
    check("R5 sync after 2 edges", cnt(), 16'h0100);
    @(negedge clk);
    check("R5 sync after 3 edges", cnt(), 16'h0101);
    pulses(4);
    check("R5 sync pulse train", cnt(), 16'h0105);

    // R6 gate
    setCtrl(mk(1, 1, 1, 0, 1, 0, 0, 0));
    writeCnt(16'h0000);
    gatePin = 1'b1; pulses(4);
    check("R6 pin low-active blocked", cnt(), 16'h0000);
    gatePin = 1'b0; pulses(4);
    check("R6 pin low-active counts", cnt(), 16'h0004);
    setCtrl(mk(1, 1, 1, 0, 1, 0, 1, 0));
    pulses(3);
    check("R6 pin high-active blocked", cnt(), 16'h0004);
    gatePin = 1'b1; pulses(3);
    check("R6 pin high-active counts", cnt(), 16'h0007);
    setCtrl(mk(1, 1, 1, 0, 1, 1, 0, 0));
    gatePin = 1'b1; cmpOut = 1'b0; pulses(2);
    check("R6 comparator counts, pin ignored", cnt(), 16'h0009);
    cmpOut = 1'b1; gatePin = 1'b0; pulses(2);
    check("R6 comparator blocks, pin ignored", cnt(), 16'h0009);
    setCtrl(mk(1, 1, 1, 0, 0, 1, 0, 0));
    pulses(2);
    check("R6 gate disabled ignores inputs", cnt(), 16'h000B);
    cmpOut = 1'b0; gatePin = 1'b0;

    // R8 write restarts prescaler
    setCtrl(mk(1, 1, 1, 3'd3, 0, 0, 0, 0));
    writeCnt(16'h0010);
    pulses(5);
    check("R8 partial ratio", cnt(), 16'h0010);
    writeCnt(16'h0020);
    pulses(7);
    check("R8 after write one short", cnt(), 16'h0020);
    pulses(1);
    check("R8 after write full ratio", cnt(), 16'h0021);

    // R7 overflow flag and interrupt
    setCtrl(mk(1, 1, 1, 0, 0, 0, 0, 0));
    writeCnt(16'hFFFE);
    pulses(1);
    check("R7 no flag before wrap", ovfFlag, 0);
    pulses(1);
    check("R7 wrap count", cnt(), 16'h0000);
    check("R7 flag set on wrap", ovfFlag, 1);
    check("R7 irq masked", irq, 0);
    setCtrl(mk(1, 1, 1, 0, 0, 0, 0, 1));
    check("R7 irq enabled", irq, 1);
    pulses(2);
    check("R7 flag sticky", ovfFlag, 1);
    @(negedge clk); flagClr = 1'b1;
    @(negedge clk); flagClr = 1'b0;
    check("R7 flag cleared", ovfFlag, 0);
    check("R7 irq cleared", irq, 0);
    // wrap wins over clear in the same cycle
    writeCnt(16'hFFFF);
    @(negedge clk); extClk = 1'b1; flagClr = 1'b1;
    @(negedge clk); extClk = 1'b0; flagClr = 1'b0;
    check("R7 wrap beats clear", ovfFlag, 1);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule